// File: doc/BRIEF.md
# Tick-Driven Run Quantum and Program-Counter Sampler

This block does the work attached to each periodic timer tick when the processor runs in one particular operating mode. It keeps a 36-bit run-quantum accumulator and a pointer-driven program-counter sampler. The accumulator grows by a fixed quantum on each qualifying tick, but only while no interrupt level is active. The quantum is the hardware count rate of 4.1 MHz divided by 60 ticks per second, which is 68333.

The sample pointer is a 36-bit word split into two 18-bit halves. The upper half holds a negative count and the lower half holds a memory address. While the pointer's sign bit is set, each tick captures the current program counter. The block then raises a single-word memory write request that carries the pointer's address. When the memory acknowledges the write, both halves of the pointer step by one at the same time, and each half wraps on its own. Sampling stops once the count reaches zero. The host can load the accumulator and the pointer directly.

Top module: `tick_quantum_sampler`

## Requirements
- R1: After reset, the accumulator is 0, the pointer is 0 (disarmed) and the memory write request is low.
- R2: A tick while the mode input is high and no interrupt level is active adds 68333 to the accumulator, modulo 2^36. The new value is visible in the cycle after the tick.
- R3: A tick while an interrupt level is active, or while the mode input is low, leaves the accumulator unchanged.
- R4: A tick while the mode input is high and pointer bit 35 is 1 raises the write request in the next cycle. The address is pointer bits 17:0 and the data is the program counter as it was at the tick. With the mode input low, or with bit 35 at 0, no request is raised.
- R5: On an acknowledge of a pending request, pointer bits 35:18 and bits 17:0 each increase by 1 modulo 2^18. No carry passes from bit 17 into bit 18. The request drops in the next cycle.
- R6: Until the acknowledge arrives, the request, its address and its data stay constant, and the pointer does not change.
- R7: A tick that arrives while a request is pending starts no new sample, but it still updates the accumulator under the R2 rule.
- R8: Once the upper half steps from all ones to zero, bit 35 is clear and later ticks raise no request.
- R9: A host load replaces the accumulator or the pointer in the next cycle, and it takes priority over a tick or acknowledge update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_en | input | 1 | Special operating mode; enables per-tick work |
| tick | input | 1 | One-cycle timer tick strobe |
| irq_active | input | 1 | High while any interrupt level is in progress |
| pc_in | input | 36 | Current program counter |
| acc_load | input | 1 | Host load strobe for the accumulator |
| acc_load_val | input | 36 | Value for the accumulator load |
| ptr_load | input | 1 | Host load strobe for the sample pointer |
| ptr_load_val | input | 36 | Value for the pointer load |
| mem_ack | input | 1 | Memory accepted the pending write |
| mem_req | output | 1 | Single-word write request |
| mem_addr | output | 18 | Write address |
| mem_wdata | output | 36 | Write data (sampled program counter) |
| acc_q | output | 36 | Run-quantum accumulator |
| ptr_q | output | 36 | Sample pointer (count half, address half) |

## Verification
The properties treat tick, acc_load, ptr_load and mem_ack as synchronous single-cycle strobes. They also treat mem_ack as meaningful only while a request is pending, because an acknowledge without a request is ignored. The bench drives every input on the falling edge, raises mem_ack only after it has seen mem_req, and holds it for one cycle. It keeps host loads apart from ticks and acknowledges, except in the single directed case that tests load priority, which the pointer-step properties exclude explicitly.

// File: rtl/tqs_pkg.sv
package tqs_pkg;
  localparam int unsigned WORD_W = 36;
  localparam int unsigned HALF_W = WORD_W / 2;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [HALF_W-1:0] half_t;

  // Accumulator step: wraps naturally at WORD_W bits.
  function automatic word_t quant_add(input word_t acc, input word_t quant);
    return acc + quant;
  endfunction

  // Pointer step: each half increments on its own, no carry between halves.
  function automatic word_t ptr_step(input word_t p);
    half_t cnt;
    half_t adr;
    cnt = p[WORD_W-1:HALF_W] + half_t'(1);
    adr = p[HALF_W-1:0] + half_t'(1);
    return {cnt, adr};
  endfunction

  // Armed while the count half is negative.
  function automatic logic ptr_armed(input word_t p);
    return p[WORD_W-1];
  endfunction
endpackage

// File: rtl/tqs_quantum_acc.sv
module tqs_quantum_acc
  import tqs_pkg::*;
#(
  parameter word_t QUANT = word_t'(68333)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step_en,
  input  logic  load_en,
  input  word_t load_val,
  output word_t acc_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       acc_q <= '0;
    else if (load_en) acc_q <= load_val;
    else if (step_en) acc_q <= quant_add(acc_q, QUANT);
  end
endmodule

// File: rtl/tqs_sample_ptr.sv
module tqs_sample_ptr
  import tqs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_en,
  input  word_t load_val,
  input  logic  advance,
  output word_t ptr_q,
  output logic  armed
);
  always_ff @(posedge clk) begin
    if (!rst_n)       ptr_q <= '0;
    else if (load_en) ptr_q <= load_val;
    else if (advance) ptr_q <= ptr_step(ptr_q);
  end

  assign armed = ptr_armed(ptr_q);
endmodule

// File: rtl/tqs_sample_req.sv
module tqs_sample_req
  import tqs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  logic  ack,
  input  half_t addr_in,
  input  word_t data_in,
  output logic  req,
  output half_t addr,
  output word_t data,
  output logic  done
);
  assign done = req & ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req  <= 1'b0;
      addr <= '0;
      data <= '0;
    end else if (done) begin
      req <= 1'b0;
    end else if (start && !req) begin
      req  <= 1'b1;
      addr <= addr_in;
      data <= data_in;
    end
  end
endmodule

// File: rtl/tick_quantum_sampler.sv
module tick_quantum_sampler
  import tqs_pkg::*;
#(
  parameter int unsigned HW_RATE   = 4100000,
  parameter int unsigned TICK_RATE = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_en,
  input  logic              tick,
  input  logic              irq_active,
  input  logic [WORD_W-1:0] pc_in,
  input  logic              acc_load,
  input  logic [WORD_W-1:0] acc_load_val,
  input  logic              ptr_load,
  input  logic [WORD_W-1:0] ptr_load_val,
  input  logic              mem_ack,
  output logic              mem_req,
  output logic [HALF_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [WORD_W-1:0] acc_q,
  output logic [WORD_W-1:0] ptr_q
);
  localparam word_t QUANT = word_t'(HW_RATE / TICK_RATE);

  // Named internal events, visible to the bound checker.
  logic tick_live;
  logic acc_step;
  logic ptr_armed_w;
  logic sample_start;
  logic sample_done;

  assign tick_live    = tick & mode_en;
  assign acc_step     = tick_live & ~irq_active;
  assign sample_start = tick_live & ptr_armed_w & ~mem_req;

  tqs_quantum_acc #(.QUANT(QUANT)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_en  (acc_step),
    .load_en  (acc_load),
    .load_val (acc_load_val),
    .acc_q    (acc_q)
  );

  tqs_sample_ptr u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (ptr_load),
    .load_val (ptr_load_val),
    .advance  (sample_done),
    .ptr_q    (ptr_q),
    .armed    (ptr_armed_w)
  );

  tqs_sample_req u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (sample_start),
    .ack      (mem_ack),
    .addr_in  (ptr_q[HALF_W-1:0]),
    .data_in  (pc_in),
    .req      (mem_req),
    .addr     (mem_addr),
    .data     (mem_wdata),
    .done     (sample_done)
  );
endmodule

// File: rtl/tqs_checker.sv
module tqs_checker
  import tqs_pkg::*;
#(
  parameter word_t QUANT = word_t'(68333)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_step,
  input logic              sample_start,
  input logic              sample_done,
  input logic              tick,
  input logic              mode_en,
  input logic              acc_load,
  input logic              ptr_load,
  input logic              mem_ack,
  input logic              mem_req,
  input logic [HALF_W-1:0] mem_addr,
  input logic [WORD_W-1:0] mem_wdata,
  input logic [WORD_W-1:0] pc_in,
  input logic [WORD_W-1:0] acc_q,
  input logic [WORD_W-1:0] ptr_q
);
  a_r2_quantum_add: assert property (@(posedge clk) disable iff (!rst_n)
    acc_step && !acc_load |=> acc_q == word_t'($past(acc_q) + QUANT));

  a_r3_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_step && !acc_load |=> $stable(acc_q));

  a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
    sample_start |=> mem_req && mem_addr == $past(ptr_q[HALF_W-1:0])
                     && mem_wdata == $past(pc_in));

  a_r4_armed_only: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req ##1 mem_req |-> $past(tick && mode_en && ptr_q[WORD_W-1]));

  a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    sample_done && !ptr_load |=>
      ptr_q[WORD_W-1:HALF_W] == half_t'($past(ptr_q[WORD_W-1:HALF_W]) + 1'b1)
      && ptr_q[HALF_W-1:0] == half_t'($past(ptr_q[HALF_W-1:0]) + 1'b1)
      && !mem_req);

  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_wdata));

  a_r6_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_done && !ptr_load |=> $stable(ptr_q));

  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !sample_start);
endmodule

bind tick_quantum_sampler tqs_checker #(.QUANT(QUANT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .acc_step     (acc_step),
  .sample_start (sample_start),
  .sample_done  (sample_done),
  .tick         (tick),
  .mode_en      (mode_en),
  .acc_load     (acc_load),
  .ptr_load     (ptr_load),
  .mem_ack      (mem_ack),
  .mem_req      (mem_req),
  .mem_addr     (mem_addr),
  .mem_wdata    (mem_wdata),
  .pc_in        (pc_in),
  .acc_q        (acc_q),
  .ptr_q        (ptr_q)
);

// File: tb/sim_tick_quantum_sampler.sv
module sim_tick_quantum_sampler;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_en, tick, irq_active, acc_load, ptr_load, mem_ack;
  logic [35:0] pc_in, acc_load_val, ptr_load_val;
  logic        mem_req;
  logic [17:0] mem_addr;
  logic [35:0] mem_wdata, acc_q, ptr_q;

  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  tick_quantum_sampler u0 (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .tick(tick),
    .irq_active(irq_active), .pc_in(pc_in), .acc_load(acc_load),
    .acc_load_val(acc_load_val), .ptr_load(ptr_load),
    .ptr_load_val(ptr_load_val), .mem_ack(mem_ack), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .acc_q(acc_q), .ptr_q(ptr_q)
  );

  // {mode, irq, start value, expected value after one tick}
  localparam int NV = 6;
  localparam logic [73:0] VEC [NV] = '{
    {1'b1, 1'b0, 36'd0,           36'd68333},
    {1'b1, 1'b1, 36'd100,         36'd100},
    {1'b0, 1'b0, 36'd100,         36'd100},
    {1'b1, 1'b0, 36'hFFFFFFFFF,   36'd68332},
    {1'b1, 1'b0, 36'hFFFFEF513,   36'd0},
    {1'b0, 1'b1, 36'd5,           36'd5}
  };

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_tick();
    tick = 1'b1; cyc(); tick = 1'b0;
  endtask

  task automatic pulse_ack();
    mem_ack = 1'b1; cyc(); mem_ack = 1'b0;
  endtask

  task automatic load_ptr(input logic [35:0] v);
    ptr_load_val = v; ptr_load = 1'b1; cyc(); ptr_load = 1'b0;
  endtask

  task automatic load_acc(input logic [35:0] v);
    acc_load_val = v; acc_load = 1'b1; cyc(); acc_load = 1'b0;
  endtask

  initial begin
    #4_000_000;
    mismatched++;
    compared++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_en = 1'b0; tick = 1'b0; irq_active = 1'b0;
    acc_load = 1'b0; ptr_load = 1'b0; mem_ack = 1'b0;
    pc_in = '0; acc_load_val = '0; ptr_load_val = '0;
    cyc(); cyc();
    // R1: reset state
    chk("R1 acc", acc_q, 36'd0);
    chk("R1 ptr", ptr_q, 36'd0);
    chk("R1 req", {35'd0, mem_req}, 36'd0);
    rst_n = 1'b1; cyc();

    // R2 / R3: table walk
    for (int i = 0; i < NV; i++) begin
      load_acc(VEC[i][71:36]);
      mode_en = VEC[i][73]; irq_active = VEC[i][72];
      pulse_tick();
      chk(VEC[i][73] && !VEC[i][72] ? "R2 table" : "R3 table", acc_q, VEC[i][35:0]);
      mode_en = 1'b0; irq_active = 1'b0;
    end

    // R4: armed pointer with mode low raises no request
    load_ptr({18'h3FFFE, 18'h00100});
    pc_in = 36'h123456789;
    pulse_tick(); cyc();
    chk("R4 mode low no req", {35'd0, mem_req}, 36'd0);

    // R4: sample capture
    mode_en = 1'b1; load_acc(36'd0);
    pulse_tick();
    pc_in = 36'hABCDE0000;
    chk("R4 req", {35'd0, mem_req}, 36'd1);
    chk("R4 addr", {18'd0, mem_addr}, 36'h00100);
    chk("R4 data", mem_wdata, 36'h123456789);

    // R6: hold while unacknowledged; R7: tick during pending
    cyc(); cyc();
    chk("R6 req held", {35'd0, mem_req}, 36'd1);
    chk("R6 addr held", {18'd0, mem_addr}, 36'h00100);
    chk("R6 ptr held", ptr_q, {18'h3FFFE, 18'h00100});
    pulse_tick();
    chk("R7 acc still steps", acc_q, 36'd136666);
    chk("R7 data unchanged", mem_wdata, 36'h123456789);

    // R5: acknowledge steps both halves
    pulse_ack();
    chk("R5 ptr step", ptr_q, {18'h3FFFF, 18'h00101});
    chk("R5 req drop", {35'd0, mem_req}, 36'd0);

    // R8: last sample, then disarmed
    pulse_tick();
    chk("R8 last addr", {18'd0, mem_addr}, 36'h00101);
    chk("R8 last data", mem_wdata, 36'hABCDE0000);
    pulse_ack();
    chk("R8 count zero", ptr_q, {18'h00000, 18'h00102});
    pulse_tick(); cyc();
    chk("R8 no further req", {35'd0, mem_req}, 36'd0);

    // R5: no carry from the address half into the count half
    load_ptr({18'h20000, 18'h3FFFF});
    pulse_tick();
    chk("R5 wrap addr", {18'd0, mem_addr}, 36'h3FFFF);
    pulse_ack();
    chk("R5 no carry", ptr_q, {18'h20001, 18'h00000});

    // R9: host load wins over tick and ack in the same cycle
    acc_load_val = 36'd42; acc_load = 1'b1; tick = 1'b1; cyc();
    acc_load = 1'b0; tick = 1'b0;
    chk("R9 acc load priority", acc_q, 36'd42);
    cyc();
    chk("R9 req from tick", {35'd0, mem_req}, 36'd1);
    ptr_load_val = 36'h0000A0005; ptr_load = 1'b1; mem_ack = 1'b1; cyc();
    ptr_load = 1'b0; mem_ack = 1'b0;
    chk("R9 ptr load priority", ptr_q, 36'h0000A0005);
    chk("R9 ack still completes", {35'd0, mem_req}, 36'd0);

    // R1: reset mid-operation
    rst_n = 1'b0; cyc();
    chk("R1 acc after reset", acc_q, 36'd0);
    chk("R1 ptr after reset", ptr_q, 36'd0);
    rst_n = 1'b1; cyc();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule